// File: doc/BRIEF.md
# Counter-Based Pulse-Width Modulator with Conversion Trigger

This block drives the switch of a digitally controlled converter and marks the instant at which the error converter should sample. A ramp counter runs from zero up to the programmed period length minus one and then starts again. While the ramp is below the active duty threshold the switch output is high, so the on-time is the duty command times the period. A second threshold on the same ramp raises a one-clock conversion trigger once per period, so the loop samples at the switching rate. The distance between the trigger point and the end of the period sets the fixed computation delay that the compensator design accounts for.

The compensator delivers duty commands as a valid/ready stream. A command can arrive at any time. It waits in a shadow register and is copied into the comparator only in the last cycle of a period, so one period never contains two duty values. The period length and the trigger threshold are plain inputs that are also sampled only in that last cycle. Full scale for a period of P counts is a duty of P; any larger value also gives a fully high period.

Back-pressure: `duty_ready_o` is low during reset and in the first cycle after it. After that it stays high, and the block never stalls the stream. A beat transfers in any cycle where valid and ready are both high. When several beats arrive within one period, only the last one is used.

Top module: `dpwm_core`

## Requirements
- R1: While reset is asserted, `pwm_o`, `trig_o` and `duty_ready_o` are low. The first clock after reset starts a period that uses the presented period and trigger inputs, with a duty of zero unless a command has been accepted.
- R2: With an active period length P (P >= 2), the ramp takes the values 0 through P-1 in turn, one per clock, and then returns to 0. A period therefore lasts P clocks.
- R3: `pwm_o` is high exactly in the clocks of a period in which the ramp value is below the active duty D. That gives D high clocks at the start of each period when D < P.
- R4: When D >= P, `pwm_o` stays high for the entire period.
- R5: When D = 0, `pwm_o` stays low for the entire period.
- R6: `trig_o` is a single-clock pulse in the clock whose ramp value equals the active trigger threshold T. There is exactly one pulse per period when T < P.
- R7: When T >= P, `trig_o` never rises.
- R8: `duty_ready_o` is high in every clock from the second clock after reset onward. An accepted beat overwrites the shadow register, so the last beat accepted before a period boundary is the one applied.
- R9: The active duty changes only at a period boundary. It takes the shadow value in the last clock of a period, and a beat accepted in that same clock is applied at that boundary.
- R10: `period_i` and `trig_i` are sampled only in the last clock of a period. Changes at other times have no effect until that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | 16 | Period length in clocks, sampled at each period boundary |
| trig_i | input | 16 | Ramp value at which the conversion trigger fires, sampled at each boundary |
| duty_valid_i | input | 1 | Duty command stream valid |
| duty_data_i | input | 16 | Duty command: number of high clocks per period |
| duty_ready_o | output | 1 | Duty command stream ready |
| pwm_o | output | 1 | Switch drive output |
| trig_o | output | 1 | One-clock conversion trigger pulse |

## Verification
The assertions assume a period input of at least two. With a period of one or zero the ramp sits at zero, and the trigger would then legally stay high for back-to-back clocks. The stimulus only ever presents period lengths of 10 and 16. It changes `period_i`, `trig_i` and the duty stream only on the falling clock edge, so every value is stable at the sampling edge. Duty beats are single-cycle pulses of valid. They are placed at chosen ramp positions, including the last clock of a period, so that the boundary transfer is exercised.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // Default ramp, threshold and command width.
  localparam int unsigned DPWM_CW = 16;

  // True in the last ramp value of a period of length per.
  // A zero length counts as an immediate boundary.
  function automatic logic last_count(input logic [DPWM_CW-1:0] cnt,
                                      input logic [DPWM_CW-1:0] per);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, per};
  endfunction
endpackage

// File: rtl/dpwm_ramp.sv
module dpwm_ramp #(
  parameter int unsigned CW = dpwm_pkg::DPWM_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] trig_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic [CW-1:0] period_act_o,
  output logic [CW-1:0] trig_act_o
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, per_q, trg_q;

  // Boundary when the next count would reach the period length.
  assign wrap_o = ({1'b0, cnt_q} + ONE) >= {1'b0, per_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      trg_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= period_i;
      trg_q <= trig_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o        = cnt_q;
  assign period_act_o = per_q;
  assign trig_act_o   = trg_q;
endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int unsigned CW = dpwm_pkg::DPWM_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          in_valid_i,
  input  logic [CW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic [CW-1:0] active_o
);
  logic          rdy_q;
  logic [CW-1:0] shd_q, act_q;
  logic          take;
  logic [CW-1:0] shd_next;

  assign take     = in_valid_i & rdy_q;
  assign shd_next = take ? in_data_i : shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      shd_q <= '0;
      act_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      shd_q <= shd_next;
      if (load_i) act_q <= shd_next;
    end
  end

  assign in_ready_o = rdy_q;
  assign active_o   = act_q;
endmodule

// File: rtl/dpwm_cmp.sv
module dpwm_cmp #(
  parameter int unsigned CW = dpwm_pkg::DPWM_CW
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] trig_i,
  output logic          pwm_o,
  output logic          trig_o
);
  assign pwm_o  = cnt_i < duty_i;
  assign trig_o = (cnt_i == trig_i) && (trig_i < period_i);
endmodule

// File: rtl/dpwm_core.sv
module dpwm_core #(
  parameter int unsigned CW = dpwm_pkg::DPWM_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] trig_i,
  input  logic          duty_valid_i,
  input  logic [CW-1:0] duty_data_i,
  output logic          duty_ready_o,
  output logic          pwm_o,
  output logic          trig_o
);
  logic [CW-1:0] cnt, per_act, trg_act, duty_act;
  logic          wrap;

  dpwm_ramp #(.CW(CW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .trig_i(trig_i),
    .cnt_o(cnt), .wrap_o(wrap), .period_act_o(per_act), .trig_act_o(trg_act)
  );

  dpwm_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load_i(wrap), .in_valid_i(duty_valid_i),
    .in_data_i(duty_data_i), .in_ready_o(duty_ready_o), .active_o(duty_act)
  );

  dpwm_cmp #(.CW(CW)) u_cmp (
    .cnt_i(cnt), .duty_i(duty_act), .period_i(per_act), .trig_i(trg_act),
    .pwm_o(pwm_o), .trig_o(trig_o)
  );
endmodule

// File: rtl/dpwm_core_chk.sv
module dpwm_core_chk #(
  parameter int unsigned CW = dpwm_pkg::DPWM_CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          duty_valid_i,
  input logic [CW-1:0] duty_data_i,
  input logic          duty_ready_o,
  input logic          pwm_o,
  input logic          trig_o,
  input logic [CW-1:0] cnt,
  input logic          wrap,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] trg_act,
  input logic [CW-1:0] duty_act
);
  assert_ramp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt < per_act));

  assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act >= 2 && duty_act >= per_act) |-> pwm_o);

  assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_o);

  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && per_act >= 2) |=> !trig_o);

  assert_trig_beyond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_act >= per_act) |-> !trig_o);

  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));

  assert_same_cycle_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && duty_valid_i && duty_ready_o) |=> (duty_act == $past(duty_data_i)));
endmodule

bind dpwm_core dpwm_core_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .duty_valid_i(duty_valid_i), .duty_data_i(duty_data_i),
  .duty_ready_o(duty_ready_o), .pwm_o(pwm_o), .trig_o(trig_o), .cnt(cnt),
  .wrap(wrap), .per_act(per_act), .trg_act(trg_act), .duty_act(duty_act)
);

// File: tb/sim_dpwm_core.sv
module sim_dpwm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_i = 16'd10;
  logic [15:0] trig_i = 16'd6;
  logic        duty_valid_i = 1'b0;
  logic [15:0] duty_data_i = '0;
  logic        duty_ready_o, pwm_o, trig_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Expected state derived from the requirements.
  int ph = 0, ep = 0, et = 0, ed = 0, esh = 0;
  bit erdy = 1'b0;

  always #5 clk = ~clk;

  dpwm_core u0 (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .trig_i(trig_i),
    .duty_valid_i(duty_valid_i), .duty_data_i(duty_data_i),
    .duty_ready_o(duty_ready_o), .pwm_o(pwm_o), .trig_o(trig_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Compare outputs at the falling edge, then advance the expected state across one clock.
  task automatic tick(input string req);
    bit acc, wr;
    chk(req, "pwm_o", int'(pwm_o), int'(ph < ed));
    chk(req, "trig_o", int'(trig_o), int'(ph == et && et < ep));
    chk("R8", "duty_ready_o", int'(duty_ready_o), int'(erdy));
    acc = duty_valid_i && erdy;
    wr  = (ph + 1 >= ep);
    if (wr) begin
      ph = 0; ep = int'(period_i); et = int'(trig_i);
      ed = acc ? int'(duty_data_i) : esh;
    end else ph++;
    if (acc) esh = int'(duty_data_i);
    erdy = 1'b1;
    @(negedge clk);
  endtask

  task automatic beat(input int val, input string req);
    duty_valid_i = 1'b1; duty_data_i = 16'(val);
    tick(req);
    duty_valid_i = 1'b0;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic wait_ph(input int p, input string req);
    while (ph != p) tick(req);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "pwm_o in reset", int'(pwm_o), 0);
    chk("R1", "trig_o in reset", int'(trig_o), 0);
    chk("R1", "duty_ready_o in reset", int'(duty_ready_o), 0);
    rst_n = 1'b1;
    run(12, "R1");
  endtask

  task automatic t_basic();
    int hi = 0, tr = 0;
    beat(4, "R3");
    run(10, "R3");
    wait_ph(0, "R3");
    for (int i = 0; i < 10; i++) begin
      hi += int'(pwm_o); tr += int'(trig_o);
      tick("R2");
    end
    chk("R3", "high clocks per period", hi, 4);
    chk("R6", "triggers per period", tr, 1);
  endtask

  task automatic t_full();
    int hi = 0;
    beat(15, "R4");
    run(10, "R4");
    wait_ph(0, "R4");
    for (int i = 0; i < 10; i++) begin hi += int'(pwm_o); tick("R4"); end
    chk("R4", "high clocks at duty above period", hi, 10);
  endtask

  task automatic t_zero();
    int hi = 0;
    beat(0, "R5");
    run(10, "R5");
    wait_ph(0, "R5");
    for (int i = 0; i < 10; i++) begin hi += int'(pwm_o); tick("R5"); end
    chk("R5", "high clocks at zero duty", hi, 0);
  endtask

  task automatic t_trig_beyond();
    int tr = 0;
    beat(5, "R7");
    trig_i = 16'd12;
    run(11, "R7");
    for (int i = 0; i < 25; i++) begin tr += int'(trig_o); tick("R7"); end
    chk("R7", "triggers with threshold past period", tr, 0);
    trig_i = 16'd3;
    run(12, "R6");
  endtask

  task automatic t_mid_update();
    wait_ph(3, "R9");
    beat(7, "R9");
    chk("R9", "duty unchanged inside period", int'(pwm_o), int'(ph < 5));
    run(12, "R9");
    wait_ph(9, "R9");
    beat(2, "R9");
    chk("R9", "same-clock beat applied at boundary", int'(pwm_o), 1);
    tick("R9");
    tick("R9");
    chk("R9", "new duty ends high phase", int'(pwm_o), 0);
    run(10, "R9");
  endtask

  task automatic t_multi();
    wait_ph(2, "R8");
    beat(8, "R8");
    beat(5, "R8");
    run(20, "R8");
  endtask

  task automatic t_period();
    int gap = 0;
    wait_ph(2, "R10");
    period_i = 16'd16;
    trig_i = 16'd4;
    run(5, "R10");
    wait_ph(0, "R10");
    while (!trig_o) tick("R10");
    tick("R10");
    while (!trig_o) begin gap++; tick("R10"); end
    chk("R2", "clocks between triggers", gap + 1, 16);
    run(34, "R2");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_zero();
    t_trig_beyond();
    t_mid_update();
    t_multi();
    t_period();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule